// File: doc/BRIEF.md
# Configurable Logic Input Conditioner

This block cleans up one asynchronous digital input before supervisory gating logic uses it. The raw pin is synchronised with two flops. It can be inverted, and a programmable glitch filter then passes a new level only after that level has held for a chosen time. The filtered signal goes to the output either as a level or, in edge mode, as a positive pulse of programmable width. The pulse starts on each rising edge.

All settings live in one 8-bit configuration byte. Software reaches it through a simple write and read port. Each instance answers at one address, set by a parameter. A group of four instances occupies addresses 0x98 to 0x9B, which serve inputs 4, 3, 2 and 1 in that order. All delays and widths count ticks of a 1 us enable. The enable is divided down from the system clock by a parameter, so every timed interval has a tolerance of plus or minus one tick.

Top module: `logic_input_conditioner`

## Requirements
- R1: After a synchronous active-low reset, the configuration reads 0x00 and `cond_o` is low.
- R2: A write at the instance address `CFG_ADDR` stores `wdata_i[6:0]`. Bit 7 always reads 0. A read at any other address returns 0x00, and a write at any other address leaves the configuration unchanged.
- R3: When configuration bit 6 is 1, the synchronised input is inverted before filtering and edge detection.
- R4: When bit 5 is 0 (level mode), `cond_o` follows the filtered level. With filter code 0, a change on `pin_i` reaches `cond_o` on the third rising clock edge.
- R5: Bits 2:0 choose the filter delay. Codes 0 to 7 give 0, 5, 10, 20, 30, 50, 75 and 100 us. A new level is accepted only after it has been stable for the full delay, within plus or minus one tick.
- R6: An input excursion shorter than the filter delay never reaches the output, because each reversal restarts the count.
- R7: When bit 5 is 1 (edge mode), a rising edge of the filtered, post-inversion signal drives `cond_o` high for a width chosen by bits 4:3. Codes 00, 01, 10 and 11 give 10, 100, 1000 and 10000 us, within one tick. After the pulse the output is low, even if the input stays high.
- R8: A rising edge that arrives while a pulse is running restarts the pulse at its full width.
- R9: Every configuration write clears the filter and pulse counters and forces the filtered level low. The output stays low until the filter accepts the input again.
- R10: The 1 us tick comes once every `CLK_PER_US` clock cycles. The filter and pulse counters advance only on a tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_i | input | 1 | Raw asynchronous logic input |
| wr_en_i | input | 1 | Configuration write strobe |
| addr_i | input | 8 | Register address for write and read |
| wdata_i | input | 8 | Configuration write data |
| rdata_o | output | 8 | Configuration read data, 0x00 when the address does not match |
| cond_o | output | 1 | Conditioned output |

## Verification
The bench builds the block with `CLK_PER_US` = 2 and `CFG_ADDR` = 0x9B. The short tick lets the 10000 us pulse width, the widest setting, finish in about twenty thousand cycles. The 100 us filter delay and retriggering are checked by timing the output across tick boundaries. Since the bench uses the address for input 1, a write to a neighbouring address (0x9A) shows that this instance ignores its neighbours.

// File: rtl/lic_pkg.sv
// Package: shared configuration type and code-to-tick tables for the
// logic input conditioner. Assumes a 1 us tick as the time base.
package lic_pkg;

    localparam int FILT_W  = 7;   // holds up to 100 ticks
    localparam int PULSE_W = 14;  // holds up to 10000 ticks

    typedef struct packed {
        logic       rsvd;        // bit 7, always zero
        logic       invert;      // bit 6
        logic       edge_mode;   // bit 5
        logic [1:0] width_code;  // bits 4:3
        logic [2:0] filt_code;   // bits 2:0
    } cfg_t;

    // Filter delay in ticks for a 3-bit code
    function automatic logic [FILT_W-1:0] filt_ticks(input logic [2:0] code);
        case (code)
            3'd0:    return FILT_W'(0);
            3'd1:    return FILT_W'(5);
            3'd2:    return FILT_W'(10);
            3'd3:    return FILT_W'(20);
            3'd4:    return FILT_W'(30);
            3'd5:    return FILT_W'(50);
            3'd6:    return FILT_W'(75);
            default: return FILT_W'(100);
        endcase
    endfunction

    // Pulse width in ticks for a 2-bit code (decade spaced)
    function automatic logic [PULSE_W-1:0] pulse_ticks(input logic [1:0] code);
        case (code)
            2'd0:    return PULSE_W'(10);
            2'd1:    return PULSE_W'(100);
            2'd2:    return PULSE_W'(1000);
            default: return PULSE_W'(10000);
        endcase
    endfunction

endpackage

// File: rtl/lic_tick_gen.sv
// Module: lic_tick_gen
// Emits a one-cycle enable every DIV clock cycles (the 1 us time base).
// Assumes DIV >= 1; with DIV = 1 the enable is held high.
module lic_tick_gen #(
    parameter int DIV = 250
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o
);

    generate
        if (DIV <= 1) begin : g_pass
            assign tick_o = 1'b1;
        end else begin : g_div
            localparam int CW = $clog2(DIV);
            localparam logic [CW-1:0] LAST = CW'(DIV - 1);
            logic [CW-1:0] cnt_q;

            // Free-running divider counter
            always_ff @(posedge clk) begin
                if (!rst_n)            cnt_q <= '0;
                else if (cnt_q == LAST) cnt_q <= '0;
                else                   cnt_q <= cnt_q + 1'b1;
            end

            assign tick_o = (cnt_q == LAST);

            // R10: ticks never come in consecutive cycles when dividing
            p_tick_gap_r10: assert property (@(posedge clk) disable iff (!rst_n)
                tick_o |=> !tick_o);
        end
    endgenerate

endmodule

// File: rtl/lic_glitch_filter.sv
// Module: lic_glitch_filter
// Accepts a new input level only after it has stayed stable for the
// programmed number of ticks; a reversal restarts the count. Code 0 is
// a registered pass-through. Assumes lvl_i is already synchronous.
module lic_glitch_filter
    import lic_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_i,
    input  logic       clr_i,
    input  logic [2:0] code_i,
    input  logic       lvl_i,
    output logic       lvl_o
);

    logic [FILT_W-1:0] dly;
    logic [FILT_W-1:0] cnt_q;
    logic              lvl_q;

    assign dly = filt_ticks(code_i);

    // Stability counter and accepted level
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            lvl_q <= 1'b0;
            cnt_q <= '0;
        end else if (dly == '0) begin
            lvl_q <= lvl_i;
            cnt_q <= '0;
        end else if (lvl_i == lvl_q) begin
            cnt_q <= '0;
        end else if (tick_i) begin
            if (cnt_q >= dly - 1'b1) begin
                lvl_q <= lvl_i;
                cnt_q <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign lvl_o = lvl_q;

    // R9: a configuration write forces the filtered level low
    p_clear_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> !lvl_o);

    // R5: with a nonzero delay the level only moves on a tick
    p_move_on_tick_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(lvl_o) && $past(code_i) != 3'd0 && !$past(clr_i)) |-> $past(tick_i));

    // R5: stability count stays below the largest delay
    p_cnt_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < FILT_W'(100));

endmodule

// File: rtl/lic_pulse_gen.sv
// Module: lic_pulse_gen
// In edge mode, turns each rising edge of the filtered level into a high
// pulse of the programmed width, counted in ticks; an edge during a pulse
// reloads the full width. Assumes lvl_i is synchronous.
module lic_pulse_gen
    import lic_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_i,
    input  logic       clr_i,
    input  logic       edge_mode_i,
    input  logic [1:0] width_code_i,
    input  logic       lvl_i,
    output logic       pulse_o
);

    logic [PULSE_W-1:0] cnt_q;
    logic               prev_q;
    logic               rise;

    assign rise = edge_mode_i && lvl_i && !prev_q;

    // Edge history and remaining pulse ticks
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            prev_q <= 1'b0;
            cnt_q  <= '0;
        end else begin
            prev_q <= lvl_i;
            if (rise)                       cnt_q <= pulse_ticks(width_code_i);
            else if (tick_i && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
        end
    end

    assign pulse_o = (cnt_q != '0);

    // R7: a rising edge in edge mode starts a pulse
    p_pulse_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rise && !clr_i) |=> pulse_o);

    // R7: a pulse only begins after the filtered level was high
    p_pulse_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pulse_o) |-> $past(lvl_i));

    // R10: without a tick or an edge the remaining width holds
    p_hold_no_tick_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_i && !rise && !clr_i) |=> $stable(cnt_q));

endmodule

// File: rtl/logic_input_conditioner.sv
// Module: logic_input_conditioner (top)
// One conditioned logic input: two-flop synchroniser, optional inversion,
// glitch filter and level/edge output stage, all controlled by one
// configuration byte at address CFG_ADDR. Assumes CLK_PER_US clock
// cycles make 1 us.
module logic_input_conditioner
    import lic_pkg::*;
#(
    parameter int         CLK_PER_US = 250,
    parameter logic [7:0] CFG_ADDR   = 8'h9B
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pin_i,
    input  logic       wr_en_i,
    input  logic [7:0] addr_i,
    input  logic [7:0] wdata_i,
    output logic [7:0] rdata_o,
    output logic       cond_o
);

    cfg_t       cfg_q;
    logic       sel;
    logic       wr_hit;
    logic [1:0] sync_q;
    logic       lvl_inv;
    logic       tick;
    logic       flt_lvl;
    logic       pulse;

    assign sel    = (addr_i == CFG_ADDR);
    assign wr_hit = wr_en_i && sel;

    // Configuration register; the reserved bit is never stored
    always_ff @(posedge clk) begin
        if (!rst_n)      cfg_q <= '0;
        else if (wr_hit) cfg_q <= cfg_t'({1'b0, wdata_i[6:0]});
    end

    assign rdata_o = sel ? cfg_q : 8'h00;

    // Two-flop synchroniser for the raw pin
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= 2'b00;
        else        sync_q <= {sync_q[0], pin_i};
    end

    assign lvl_inv = sync_q[1] ^ cfg_q.invert;

    lic_tick_gen #(.DIV(CLK_PER_US)) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_o (tick)
    );

    lic_glitch_filter u_filt (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_i (tick),
        .clr_i  (wr_hit),
        .code_i (cfg_q.filt_code),
        .lvl_i  (lvl_inv),
        .lvl_o  (flt_lvl)
    );

    lic_pulse_gen u_pulse (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick_i       (tick),
        .clr_i        (wr_hit),
        .edge_mode_i  (cfg_q.edge_mode),
        .width_code_i (cfg_q.width_code),
        .lvl_i        (flt_lvl),
        .pulse_o      (pulse)
    );

    assign cond_o = cfg_q.edge_mode ? pulse : flt_lvl;

    // R2: a hit stores the low seven data bits with bit 7 cleared
    p_cfg_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hit |=> (cfg_q == cfg_t'({1'b0, $past(wdata_i[6:0])})));

    // R2: without a hit the configuration holds
    p_cfg_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_hit |=> $stable(cfg_q));

    // R9: the output is low in the cycle after any configuration write
    p_out_low_after_wr_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hit |=> !cond_o);

endmodule

// File: tb/logic_input_conditioner_tb_top.sv
// Directed bench for logic_input_conditioner: one task per scenario.
module logic_input_conditioner_tb_top;

    localparam int         CPU  = 2;
    localparam logic [7:0] ADDR = 8'h9B;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pin = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] addr = ADDR;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic       cond;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;  // 250 MHz

    logic_input_conditioner #(.CLK_PER_US(CPU), .CFG_ADDR(ADDR)) dut_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .pin_i   (pin),
        .wr_en_i (wr_en),
        .addr_i  (addr),
        .wdata_i (wdata),
        .rdata_o (rdata),
        .cond_o  (cond)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic clks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic us(input int n);
        repeat (n * CPU) @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0; addr = ADDR;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        addr = a;
        #1 d = rdata;
        addr = ADDR;
    endtask

    // R1: reset state
    task automatic t_reset();
        logic [7:0] d;
        rd(ADDR, d);
        chk("R1 cfg after reset", d, 8'h00);
        chk("R1 output after reset", {7'b0, cond}, 8'h00);
    endtask

    // R2: own address, reserved bit, neighbour address
    task automatic t_regs();
        logic [7:0] d;
        wr(ADDR, 8'hFF);
        rd(ADDR, d);
        chk("R2 bit7 reads 0", d, 8'h7F);
        wr(8'h9A, 8'h55);
        rd(ADDR, d);
        chk("R2 other address write ignored", d, 8'h7F);
        rd(8'h9A, d);
        chk("R2 other address reads 0", d, 8'h00);
        wr(ADDR, 8'h00);
        clks(5);
    endtask

    // R4: level mode, filter code 0, three-edge latency
    task automatic t_level();
        pin = 1'b1;
        clks(2);
        chk("R4 not yet through synchroniser", {7'b0, cond}, 8'h00);
        clks(1);
        chk("R4 level reaches output on third edge", {7'b0, cond}, 8'h01);
        pin = 1'b0;
        clks(5);
        chk("R4 level low follows", {7'b0, cond}, 8'h00);
    endtask

    // R3: inversion
    task automatic t_invert();
        wr(ADDR, 8'h40);
        clks(5);
        chk("R3 inverted low input", {7'b0, cond}, 8'h01);
        pin = 1'b1;
        clks(5);
        chk("R3 inverted high input", {7'b0, cond}, 8'h00);
        pin = 1'b0;
        wr(ADDR, 8'h00);
        clks(5);
    endtask

    // R5 R10: 20 us filter timed in ticks
    task automatic t_filter20();
        wr(ADDR, 8'h03);
        clks(5);
        pin = 1'b1;
        us(15);
        chk("R5 20us filter still low at 15us", {7'b0, cond}, 8'h00);
        us(9);
        chk("R5 20us filter high at 24us", {7'b0, cond}, 8'h01);
        pin = 1'b0;
        us(15);
        chk("R5 20us filter still high at 15us", {7'b0, cond}, 8'h01);
        us(10);
        chk("R5 20us filter low at 25us", {7'b0, cond}, 8'h00);
    endtask

    // R6: short excursions rejected (filter 20 us still set)
    task automatic t_glitch();
        pin = 1'b1; us(12);
        chk("R6 glitch not passed mid-run", {7'b0, cond}, 8'h00);
        pin = 1'b0; us(12);
        pin = 1'b1; us(12);
        pin = 1'b0; us(40);
        chk("R6 repeated short glitches rejected", {7'b0, cond}, 8'h00);
    endtask

    // R5 R10: 100 us filter
    task automatic t_filter100();
        wr(ADDR, 8'h07);
        clks(5);
        pin = 1'b1;
        us(90);
        chk("R5 100us filter low at 90us", {7'b0, cond}, 8'h00);
        us(20);
        chk("R5 100us filter high at 110us", {7'b0, cond}, 8'h01);
        pin = 1'b0;
        wr(ADDR, 8'h00);
        clks(5);
    endtask

    // R7: pulse widths for each code, filter 0
    task automatic t_edge(input logic [1:0] code, input int width_us);
        wr(ADDR, 8'h20 | {3'b000, code, 3'b000});
        clks(5);
        pin = 1'b1;
        us(width_us / 2);
        chk("R7 pulse high mid-width", {7'b0, cond}, 8'h01);
        us(width_us / 2 + 3);
        chk("R7 pulse ended with input still high", {7'b0, cond}, 8'h00);
        pin = 1'b0;
        clks(5);
    endtask

    // R8: retrigger on a new edge during a 100 us pulse
    task automatic t_retrig();
        wr(ADDR, 8'h28);
        clks(5);
        pin = 1'b1; us(60);
        pin = 1'b0; us(10);
        pin = 1'b1; us(85);
        chk("R8 retriggered pulse still high at 155us", {7'b0, cond}, 8'h01);
        us(20);
        chk("R8 retriggered pulse ended by 175us", {7'b0, cond}, 8'h00);
        pin = 1'b0;
        clks(5);
    endtask

    // R9: configuration write clears the filter
    task automatic t_cfg_clear();
        wr(ADDR, 8'h03);
        clks(5);
        pin = 1'b1;
        us(30);
        chk("R9 settled high before rewrite", {7'b0, cond}, 8'h01);
        wr(ADDR, 8'h03);
        chk("R9 low right after write", {7'b0, cond}, 8'h00);
        us(15);
        chk("R9 still low while refiltering", {7'b0, cond}, 8'h00);
        us(10);
        chk("R9 high once filter settles", {7'b0, cond}, 8'h01);
        pin = 1'b0;
        wr(ADDR, 8'h00);
        clks(5);
    endtask

    initial begin
        clks(4);
        rst_n = 1'b1;
        clks(2);
        t_reset();
        t_regs();
        t_level();
        t_invert();
        t_filter20();
        t_glitch();
        t_filter100();
        t_edge(2'd0, 10);
        t_edge(2'd1, 100);
        t_edge(2'd2, 1000);
        t_edge(2'd3, 10000);
        t_retrig();
        t_cfg_clear();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule